// File: doc/BRIEF.md
# Dual-Bus General-Purpose Register Bank

This block is a set of general-purpose registers that sits between two internal data buses of a processor datapath, called here the A bus and the B bus. In every clock cycle, each register has its own enable to put its contents on the A bus and on the B bus. It also has its own enable to capture the value carried on each bus. The buses are modelled as multiplexed ports rather than tri-state wires. Each bus has one output port, which carries the value the bank drives. Each bus also has one input port, which carries the value the rest of the datapath presents for loading.

The bank does not block control combinations that are forbidden. Keeping them from happening is the sequencing logic's job. Instead, the bank resolves them in a fixed way and reports them on two conflict outputs, which verification can watch:
- When several registers drive one bus, the lowest-numbered register wins.
- When one register loads from both buses at once, the B value wins.

A parameter chooses whether a single register may drive both buses in the same cycle. The register count and the data width are parameters.

Top module: `regbank_dual_bus`

## Requirements
- R1: An active-low reset clears every register to zero, so after reset any register read on a bus shows 0.
- R2: In the same cycle that a register's drive enable for a bus is high, that register's current value appears on that bus output, and the bus valid flag for that bus is 1.
- R3: With DUAL_DRIVE=1, a register whose A and B drive enables are both high shows its value on both bus outputs in that cycle, and no drive conflict is flagged for that reason.
- R4: With DUAL_DRIVE=0, a register whose A and B drive enables are both high drives only the A bus. Its B drive enable is ignored, and drive_conflict is 1.
- R5: A bus with no drive enable set reads as all zeros, and its valid flag is 0.
- R6: When more than one register is enabled to drive the same bus, that bus carries the value of the lowest-index enabled register, and drive_conflict is 1.
- R7: A register whose load enable for a bus is high takes that bus's input value at the rising clock edge. The new value is visible on the buses from the next cycle only: a read in the loading cycle shows the old value.
- R8: A register can load from one bus while it drives the other bus in the same cycle. The driven bus shows the pre-load value.
- R9: Two different registers can load in the same cycle, one from the A bus and one from the B bus, and each gets its own bus's value.
- R10: A register with both load enables high takes the B bus input value, and load_conflict is 1 in that cycle.
- R11: A register with neither load enable high keeps its value across the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all loads happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| drv_a_en | input | NREG | Per-register enable to drive the A bus |
| drv_b_en | input | NREG | Per-register enable to drive the B bus |
| ld_a_en | input | NREG | Per-register enable to load from the A bus |
| ld_b_en | input | NREG | Per-register enable to load from the B bus |
| bus_a_in | input | WIDTH | Value on the A bus offered for loading |
| bus_b_in | input | WIDTH | Value on the B bus offered for loading |
| bus_a_out | output | WIDTH | Value the bank drives on the A bus |
| bus_b_out | output | WIDTH | Value the bank drives on the B bus |
| bus_a_valid | output | 1 | Some register drives the A bus |
| bus_b_valid | output | 1 | Some register drives the B bus |
| drive_conflict | output | 1 | More than one driver on a bus, or a forbidden dual drive |
| load_conflict | output | 1 | Some register has both load enables high |

## Verification
Register contents can only be seen through the drive enables. A corrupted register therefore stays hidden until that register is next driven, and it then shows in that same cycle as a wrong bus value. The bench reads registers often, so a bad load or a lost hold is exposed within a few cycles of the edge that caused it. A wrong drive priority, a missing zero on an idle bus, or a wrong conflict flag shows in the very cycle that the enables are applied, because those outputs have no register in their path.

// File: rtl/regbank_pkg.sv
// Shared definitions for the dual-bus register bank.
// Assumes: a loading register chooses its source from two bus inputs;
// when both enables are set the B bus takes precedence.
package regbank_pkg;

    typedef enum logic [1:0] {
        LD_HOLD   = 2'd0,
        LD_FROM_A = 2'd1,
        LD_FROM_B = 2'd2
    } ld_src_e;

    // Select the capture source; B wins over A when both are requested.
    function automatic ld_src_e pick_src(input logic from_a, input logic from_b);
        if (from_b) return LD_FROM_B;
        if (from_a) return LD_FROM_A;
        return LD_HOLD;
    endfunction

endpackage

// File: rtl/rb_cell.sv
// One storage word of the register bank.
// Captures the A or B bus input on the rising edge when enabled, holds
// otherwise. Assumes a synchronous active-low reset that clears the word.
module rb_cell
    import regbank_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_a,
    input  logic             ld_b,
    input  logic [WIDTH-1:0] bus_a,
    input  logic [WIDTH-1:0] bus_b,
    output logic [WIDTH-1:0] q
);

    ld_src_e src;

    // Decode the capture source for this cycle.
    always_comb src = pick_src(ld_a, ld_b);

    // Storage update: reset, capture from a bus, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (src)
                LD_FROM_A: q <= bus_a;
                LD_FROM_B: q <= bus_b;
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/rb_bus_sel.sv
// Bus driver model for one bus: selects the word of the lowest-index
// enabled register, reports whether any register drives and whether
// more than one does. Assumes an idle bus must read as all zeros.
module rb_bus_sel #(
    parameter int NREG  = 8,
    parameter int WIDTH = 16
) (
    input  logic [NREG-1:0]            en,
    input  logic [NREG-1:0][WIDTH-1:0] words,
    output logic [WIDTH-1:0]           out,
    output logic                       valid,
    output logic                       multi
);

    localparam int CW = $clog2(NREG + 1);

    logic [CW-1:0] drv_cnt;

    // Priority select: scanning downward leaves the lowest index last.
    always_comb begin
        out = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (en[i]) out = words[i];
        end
    end

    // Count active drivers to flag contention.
    always_comb begin
        drv_cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            drv_cnt = drv_cnt + CW'(en[i]);
        end
    end

    assign valid = |en;
    assign multi = (drv_cnt > CW'(1));

endmodule

// File: rtl/regbank_dual_bus.sv
// Dual-bus general-purpose register bank.
// Every register has its own drive and load enables for the A and B
// buses. Bus outputs are combinational from the stored words, so a load
// becomes visible only in the cycle after its edge (no write bypass).
// Forbidden control combinations are resolved, not prevented: the lowest
// driver wins a bus, B wins a double load, and both cases are flagged.
// DUAL_DRIVE=0 forbids one register on both buses; it then drives A only.
module regbank_dual_bus #(
    parameter int NREG       = 8,
    parameter int WIDTH      = 16,
    parameter bit DUAL_DRIVE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREG-1:0]  drv_a_en,
    input  logic [NREG-1:0]  drv_b_en,
    input  logic [NREG-1:0]  ld_a_en,
    input  logic [NREG-1:0]  ld_b_en,
    input  logic [WIDTH-1:0] bus_a_in,
    input  logic [WIDTH-1:0] bus_b_in,
    output logic [WIDTH-1:0] bus_a_out,
    output logic [WIDTH-1:0] bus_b_out,
    output logic             bus_a_valid,
    output logic             bus_b_valid,
    output logic             drive_conflict,
    output logic             load_conflict
);

    logic [NREG-1:0][WIDTH-1:0] reg_q;
    logic [NREG-1:0]            drv_b_eff;
    logic                       both_drive;
    logic                       multi_a;
    logic                       multi_b;

    // Storage: one cell per register.
    for (genvar g = 0; g < NREG; g++) begin : g_cell
        rb_cell #(.WIDTH(WIDTH)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .ld_a  (ld_a_en[g]),
            .ld_b  (ld_b_en[g]),
            .bus_a (bus_a_in),
            .bus_b (bus_b_in),
            .q     (reg_q[g])
        );
    end

    // Dual-drive policy: pass B enables through, or mask those already on A.
    if (DUAL_DRIVE) begin : g_dual
        assign drv_b_eff  = drv_b_en;
        assign both_drive = 1'b0;
    end else begin : g_single
        assign drv_b_eff  = drv_b_en & ~drv_a_en;
        assign both_drive = |(drv_a_en & drv_b_en);
    end

    // A bus driver.
    rb_bus_sel #(.NREG(NREG), .WIDTH(WIDTH)) u_sel_a (
        .en    (drv_a_en),
        .words (reg_q),
        .out   (bus_a_out),
        .valid (bus_a_valid),
        .multi (multi_a)
    );

    // B bus driver.
    rb_bus_sel #(.NREG(NREG), .WIDTH(WIDTH)) u_sel_b (
        .en    (drv_b_eff),
        .words (reg_q),
        .out   (bus_b_out),
        .valid (bus_b_valid),
        .multi (multi_b)
    );

    // Conflict reporting for the sequencing logic's verification.
    assign drive_conflict = multi_a | multi_b | both_drive;
    assign load_conflict  = |(ld_a_en & ld_b_en);

endmodule

// File: rtl/rb_checker.sv
// Property checker for the dual-bus register bank, attached by bind.
// Observes the ports plus the stored words; holds from reset release.
module rb_checker #(
    parameter int NREG       = 8,
    parameter int WIDTH      = 16,
    parameter bit DUAL_DRIVE = 1'b1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NREG-1:0]            drv_a_en,
    input logic [NREG-1:0]            drv_b_en,
    input logic [NREG-1:0]            ld_a_en,
    input logic [NREG-1:0]            ld_b_en,
    input logic [WIDTH-1:0]           bus_a_in,
    input logic [WIDTH-1:0]           bus_b_in,
    input logic [WIDTH-1:0]           bus_a_out,
    input logic [WIDTH-1:0]           bus_b_out,
    input logic                       bus_a_valid,
    input logic                       bus_b_valid,
    input logic                       drive_conflict,
    input logic                       load_conflict,
    input logic [NREG-1:0][WIDTH-1:0] q
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == '0));

    assert_idle_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_a_en == '0) |-> (bus_a_out == '0 && !bus_a_valid));

    assert_idle_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_b_en == '0) |-> (bus_b_out == '0 && !bus_b_valid));

    assert_multi_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(drv_a_en) > 1) |-> drive_conflict);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        assert_drive_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (drv_a_en == (NREG'(1) << i)) |-> (bus_a_out == q[i] && bus_a_valid));

        assert_load_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_a_en[i] && !ld_b_en[i]) |=> (q[i] == $past(bus_a_in)));

        assert_load_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ld_b_en[i] |=> (q[i] == $past(bus_b_in)));

        assert_both_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_a_en[i] && ld_b_en[i]) |-> load_conflict);

        assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!ld_a_en[i] && !ld_b_en[i]) |=> $stable(q[i]));

        if (DUAL_DRIVE) begin : g_dual
            assert_dual_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (drv_b_en == (NREG'(1) << i)) |-> (bus_b_out == q[i] && bus_b_valid));
        end else begin : g_single
            assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (drv_a_en[i] && drv_b_en[i]) |-> drive_conflict);
        end
    end

endmodule

bind regbank_dual_bus rb_checker #(
    .NREG       (NREG),
    .WIDTH      (WIDTH),
    .DUAL_DRIVE (DUAL_DRIVE)
) u_rb_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .drv_a_en       (drv_a_en),
    .drv_b_en       (drv_b_en),
    .ld_a_en        (ld_a_en),
    .ld_b_en        (ld_b_en),
    .bus_a_in       (bus_a_in),
    .bus_b_in       (bus_b_in),
    .bus_a_out      (bus_a_out),
    .bus_b_out      (bus_b_out),
    .bus_a_valid    (bus_a_valid),
    .bus_b_valid    (bus_b_valid),
    .drive_conflict (drive_conflict),
    .load_conflict  (load_conflict),
    .q              (reg_q)
);

// File: tb/regbank_dual_bus_tb.sv
// Bench: small 4x8 bank, two instances (dual drive allowed / forbidden),
// directed cases then exhaustive drive and load enable sweeps.
module regbank_dual_bus_tb;

    localparam int N = 4;
    localparam int W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic [N-1:0] da, db, la, lb;
    logic [W-1:0] ia, ib;
    logic [W-1:0] ao1, bo1, ao2, bo2;
    logic         av1, bv1, dc1, lc1, av2, bv2, dc2, lc2;

    logic [W-1:0] m [N];
    int vec  = 0;
    int bad  = 0;
    bit done = 1'b0;

    regbank_dual_bus #(.NREG(N), .WIDTH(W), .DUAL_DRIVE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .drv_a_en(da), .drv_b_en(db),
        .ld_a_en(la), .ld_b_en(lb), .bus_a_in(ia), .bus_b_in(ib),
        .bus_a_out(ao1), .bus_b_out(bo1), .bus_a_valid(av1), .bus_b_valid(bv1),
        .drive_conflict(dc1), .load_conflict(lc1)
    );

    regbank_dual_bus #(.NREG(N), .WIDTH(W), .DUAL_DRIVE(1'b0)) u_dut_sd (
        .clk(clk), .rst_n(rst_n), .drv_a_en(da), .drv_b_en(db),
        .ld_a_en(la), .ld_b_en(lb), .bus_a_in(ia), .bus_b_in(ib),
        .bus_a_out(ao2), .bus_b_out(bo2), .bus_a_valid(av2), .bus_b_valid(bv2),
        .drive_conflict(dc2), .load_conflict(lc2)
    );

    task automatic chk(input int act, input int exp, input string tag, input string what);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] e);
        for (int i = 0; i < N; i++) if (e[i]) return i;
        return -1;
    endfunction

    function automatic int pop(input logic [N-1:0] e);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(e[i]);
        return c;
    endfunction

    function automatic int bus_val(input logic [N-1:0] e);
        int k = lowest(e);
        return (k < 0) ? 0 : int'(m[k]);
    endfunction

    function automatic string bus_tag(input logic [N-1:0] e);
        if (pop(e) == 0) return "R5";
        if (pop(e) > 1)  return "R6";
        return "R2";
    endfunction

    // Compare all outputs of both instances against the bench model.
    task automatic check_all();
        logic [N-1:0] dbe;
        string tb1, tb2;
        dbe = db & ~da;
        tb1 = ((da & db) != '0 && pop(db) == 1) ? "R3" : bus_tag(db);
        tb2 = ((da & db) != '0) ? "R4" : bus_tag(dbe);
        chk(int'(ao1), bus_val(da), bus_tag(da), "dual A data");
        chk(int'(av1), int'(da != '0), bus_tag(da), "dual A valid");
        chk(int'(bo1), bus_val(db), tb1, "dual B data");
        chk(int'(bv1), int'(db != '0), tb1, "dual B valid");
        chk(int'(dc1), int'(pop(da) > 1 || pop(db) > 1), "R6", "dual drive_conflict");
        chk(int'(lc1), int'((la & lb) != '0), "R10", "dual load_conflict");
        chk(int'(ao2), bus_val(da), bus_tag(da), "single A data");
        chk(int'(bo2), bus_val(dbe), tb2, "single B data");
        chk(int'(bv2), int'(dbe != '0), tb2, "single B valid");
        chk(int'(dc2), int'(pop(da) > 1 || pop(dbe) > 1 || (da & db) != '0),
            "R4", "single drive_conflict");
        chk(int'(lc2), int'((la & lb) != '0), "R10", "single load_conflict");
    endtask

    // Apply one cycle of controls, check outputs, then advance the model.
    task automatic step(input logic [N-1:0] da_, db_, la_, lb_,
                        input logic [W-1:0] ia_, ib_);
        da = da_; db = db_; la = la_; lb = lb_; ia = ia_; ib = ib_;
        #1;
        check_all();
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (lb[i])      m[i] = ib;
            else if (la[i]) m[i] = ia;
        end
        @(negedge clk);
    endtask

    // Read one register on the A bus and compare with an explicit value.
    task automatic rd(input int idx, input logic [W-1:0] exp, input string tag);
        da = N'(1) << idx; db = '0; la = '0; lb = '0;
        #1;
        chk(int'(ao1), int'(exp), tag, "dual readback");
        chk(int'(ao2), int'(exp), tag, "single readback");
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        da = '0; db = '0; la = '0; lb = '0; ia = '0; ib = '0;
        for (int i = 0; i < N; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(int'(ao1), 0, "R5", "idle A in reset");
        chk(int'(av1), 0, "R5", "idle A valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < N; i++) rd(i, 8'h00, "R1");

        // R7: load reg1 from A while reading it on B (old value seen)
        step(4'b0000, 4'b0010, 4'b0010, 4'b0000, 8'h5A, 8'h00);
        rd(1, 8'h5A, "R7");
        // R8: drive reg2 on A while it loads from B
        step(4'b0100, 4'b0000, 4'b0000, 4'b0100, 8'h00, 8'hC3);
        rd(2, 8'hC3, "R8");
        // R9: reg0 from A and reg3 from B in one cycle
        step(4'b0000, 4'b0000, 4'b0001, 4'b1000, 8'h21, 8'h84);
        rd(0, 8'h21, "R9");
        rd(3, 8'h84, "R9");
        // R10: reg2 loads from both buses, B wins
        step(4'b0000, 4'b0000, 4'b0100, 4'b0100, 8'hAA, 8'h55);
        rd(2, 8'h55, "R10");
        // R3 / R4: reg1 on both buses
        step(4'b0010, 4'b0010, 4'b0000, 4'b0000, 8'h00, 8'h00);
        // R11: no load enables, bus inputs change
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 8'hFF, 8'hFF);
        rd(1, 8'h5A, "R11");

        // Fill registers with distinct values
        for (int i = 0; i < N; i++)
            step('0, '0, N'(1) << i, '0, W'(16 * i + 3), '0);
        // Exhaustive drive enable sweep
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                step(N'(a), N'(b), '0, '0, '0, '0);
        // Exhaustive load enable sweep with mixed drives
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                step(N'(a ^ b), N'(a), N'(a), N'(b), W'(a * 16 + b), ~W'(b * 16 + a));
        for (int i = 0; i < N; i++) rd(i, m[i], "R11");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule